// File: doc/BRIEF.md
# Fixed-Point to Compact Float Converter

This block turns a signed two's-complement fixed-point sample into a compact 16-bit floating-point word. The default input has 6 integer bits, the sign included, above 10 fraction bits. The output holds a sign bit, a 4-bit exponent with a bias of 7, and 11 stored mantissa bits. The leading one of the normalized magnitude is implied and is not stored. The conversion truncates and does not round.

Inside, the input goes to magnitude form first. A leading-zero count then sets a left shift that normalizes the magnitude. The same count gives the exponent as (integer bits − 1 + bias) − count. Magnitudes too small for the exponent field are flushed to a signed zero and flagged. Zero and the most negative input are handled explicitly.

One strobe on `in_valid` gives one registered result, with `out_valid`, on the next clock edge. The widths, the integer-bit count and the bias are parameters.

Top module: `fxp2flt_conv`

## Requirements
- R1: Output bit 15 equals input bit 15. A negative input is converted using its two's-complement magnitude, so an input and its negation give the same bits [14:0].
- R2: The mantissa field, bits [10:0], holds the 11 magnitude bits just below the leading one. These bits are truncated, and the leading one is not stored.
- R3: The exponent field, bits [14:11], equals 12 − (leading zeros of the 16-bit magnitude). This is (6 − 1) + 7, and it never exceeds 12.
- R4: The output word is packed as {sign, exponent, mantissa}. Input 0x2080 (8.125) gives 0x5020, and input 0x0400 (1.0) gives 0x3800.
- R5: Input 0x0000 gives output 0x0000 with `underflow` low.
- R6: Input 0x8000 (magnitude 32768) gives 0xE000: sign 1, exponent 12, mantissa 0.
- R7: A nonzero magnitude of 1 to 7 (more than 12 leading zeros) gives {sign, 15'b0}, and `underflow` is high in the same cycle as `out_valid`. A magnitude of 8 gives exponent 0 with `underflow` low.
- R8: A strobe on `in_valid` gives `out_valid` and the result one clock later. Back-to-back strobes give back-to-back results. Without a strobe, `out_valid` and `underflow` are low and `out_word` holds its last value.
- R9: While the synchronous active-high `rst` is sampled high, `out_valid`, `underflow` and `out_word` are all zero, even if `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: convert `in_data` this cycle |
| in_data | input | 16 | Signed fixed-point input (6 integer bits, 10 fraction bits) |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_word | output | 16 | Float result {sign, exponent, mantissa} |
| underflow | output | 1 | Result was flushed to signed zero |

## Verification
Several directed values test one rule each.
- The worked value 0x2080 and 1.0 fix the field packing.
- 0x7FFF fixes mantissa truncation.
- 0x8000 shows that the magnitude path does not overflow.
- Magnitude 8 against magnitude 7 fixes the underflow threshold to the exact count.
- Zero against −1 separates a true zero from a flushed signed zero.

Random words over the full range, small signed magnitudes, and signed powers of two then reach every leading-zero count and both signs. A back-to-back pair and the idle cycles after each strobe separate the one-cycle latency from a result that is held or repeated.

// File: rtl/f2f_pkg.sv
package f2f_pkg;

   // How the negative input is brought to magnitude form
   typedef enum logic [0:0] {
      MAG_SUB     = 1'b0,   // zero minus input
      MAG_INV_INC = 1'b1    // one's complement plus one
   } mag_style_e;

   function automatic int f2f_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fxp_mag.sv
module fxp_mag
   import f2f_pkg::*;
#(
   parameter int         W     = 16,
   parameter mag_style_e STYLE = MAG_INV_INC
) (
   input  logic [W-1:0] x,
   output logic [W-1:0] mag,
   output logic         neg
);

   assign neg = x[W-1];

   generate
      if (STYLE == MAG_SUB) begin : g_sub
         assign mag = neg ? ('0 - x) : x;
      end else begin : g_inv
         assign mag = neg ? (~x + 1'b1) : x;
      end
   endgenerate

endmodule

// File: rtl/fxp_lzc.sv
module fxp_lzc #(
   parameter int W  = 16,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  v,
   output logic [CW-1:0] cnt,
   output logic          zero
);

   // The scan runs upward, so the highest set bit writes the count last.
   always_comb begin
      cnt = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (v[i]) cnt = CW'(W - 1 - i);
      end
   end

   assign zero = ~|v;

endmodule

// File: rtl/fxp_lshift.sv
module fxp_lshift #(
   parameter int W  = 16,
   parameter int SW = $clog2(W)
) (
   input  logic [W-1:0]  v,
   input  logic [SW-1:0] amt,
   output logic [W-1:0]  y
);

   logic [W-1:0] st [0:SW];

   assign st[0] = v;

   // Logarithmic barrel: stage k shifts by 2**k
   generate
      for (genvar k = 0; k < SW; k++) begin : g_stage
         assign st[k+1] = amt[k] ? (st[k] << (2 ** k)) : st[k];
      end
   endgenerate

   assign y = st[SW];

endmodule

// File: rtl/fxp_expo.sv
module fxp_expo #(
   parameter int CW    = 5,
   parameter int EXP_W = 4,
   parameter int INT_W = 6,
   parameter int BIAS  = 7
) (
   input  logic [CW-1:0]    cnt,
   input  logic             zero,
   output logic [EXP_W-1:0] expo,
   output logic             uf
);

   localparam int CALC_W = f2f_pkg::f2f_max(CW, EXP_W) + 2;

   logic signed [CALC_W-1:0] unbiased;
   logic signed [CALC_W-1:0] biased;

   // Two narrow steps: subtract the count, then add the bias
   assign unbiased = $signed(CALC_W'(INT_W - 1)) - $signed(CALC_W'(cnt));
   assign biased   = unbiased + $signed(CALC_W'(BIAS));

   assign uf   = !zero && biased[CALC_W-1];
   assign expo = biased[EXP_W-1:0];

   logic unused_hi;
   assign unused_hi = ^biased[CALC_W-2:EXP_W];

endmodule

// File: rtl/fxp2flt_conv.sv
module fxp2flt_conv
   import f2f_pkg::*;
#(
   parameter int         IN_W      = 16,
   parameter int         INT_W     = 6,
   parameter int         EXP_W     = 4,
   parameter int         MAN_W     = 11,
   parameter int         BIAS      = 7,
   parameter mag_style_e MAG_STYLE = MAG_INV_INC
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic [IN_W-1:0]        in_data,
   output logic                   out_valid,
   output logic [EXP_W+MAN_W:0]   out_word,
   output logic                   underflow
);

   localparam int CW    = $clog2(IN_W + 1);
   localparam int SW    = $clog2(IN_W);
   localparam int OUT_W = 1 + EXP_W + MAN_W;
   localparam int TOPX  = INT_W - 1 + BIAS;
   localparam int DROP  = IN_W - 1 - MAN_W;

   // Elaboration-time parameter checks
   generate
      if (MAN_W > IN_W - 1) begin : g_bad_man
         $error("MAN_W must not exceed IN_W-1");
      end
      if (INT_W < 1 || INT_W > IN_W) begin : g_bad_int
         $error("INT_W must lie in 1..IN_W");
      end
      if (BIAS < 0 || TOPX >= (2 ** EXP_W)) begin : g_bad_exp
         $error("largest biased exponent does not fit EXP_W");
      end
   endgenerate

   logic [IN_W-1:0]  mag;
   logic             neg;
   logic [CW-1:0]    lzc;
   logic             is_zero;
   logic [IN_W-1:0]  norm;
   logic [EXP_W-1:0] expo;
   logic             uf_c;
   logic [MAN_W-1:0] mant;
   logic [OUT_W-1:0] word_c;

   fxp_mag #(.W(IN_W), .STYLE(MAG_STYLE)) u_mag (
      .x   (in_data),
      .mag (mag),
      .neg (neg)
   );

   fxp_lzc #(.W(IN_W), .CW(CW)) u_lzc (
      .v    (mag),
      .cnt  (lzc),
      .zero (is_zero)
   );

   fxp_lshift #(.W(IN_W), .SW(SW)) u_shift (
      .v   (mag),
      .amt (lzc[SW-1:0]),
      .y   (norm)
   );

   fxp_expo #(.CW(CW), .EXP_W(EXP_W), .INT_W(INT_W), .BIAS(BIAS)) u_expo (
      .cnt  (lzc),
      .zero (is_zero),
      .expo (expo),
      .uf   (uf_c)
   );

   // Hidden one at norm[IN_W-1]; mantissa taken just below it
   assign mant = norm[IN_W-2 -: MAN_W];

   generate
      if (DROP > 0) begin : g_drop
         logic unused_norm;
         assign unused_norm = ^{norm[IN_W-1], norm[DROP-1:0]};
      end else begin : g_nodrop
         logic unused_norm;
         assign unused_norm = norm[IN_W-1];
      end
   endgenerate

   always_comb begin
      if (is_zero) begin
         word_c = '0;
      end else if (uf_c) begin
         word_c = {neg, {(OUT_W-1){1'b0}}};
      end else begin
         word_c = {neg, expo, mant};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         underflow <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= in_valid;
         underflow <= in_valid & uf_c;
         if (in_valid) out_word <= word_c;
      end
   end

endmodule

// File: rtl/fxp2flt_chk.sv
module fxp2flt_chk #(
   parameter int IN_W  = 16,
   parameter int INT_W = 6,
   parameter int EXP_W = 4,
   parameter int MAN_W = 11,
   parameter int BIAS  = 7
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 in_valid,
   input logic [IN_W-1:0]      in_data,
   input logic                 out_valid,
   input logic [EXP_W+MAN_W:0] out_word,
   input logic                 underflow
);

   localparam int TOPX = INT_W - 1 + BIAS;
   localparam int OW   = 1 + EXP_W + MAN_W;

   // R1: sign follows the input MSB
   p_sign_r1: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_word[OW-1] == $past(in_data[IN_W-1]));

   // R3: exponent never exceeds the top biased value
   p_exp_top_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_word[OW-2 -: EXP_W] <= EXP_W'(TOPX));

   // R5: zero maps to zero without underflow
   p_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_data == '0) |=> (out_word == '0 && !underflow));

   // R6: most negative input
   p_min_neg_r6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_data == {1'b1, {(IN_W-1){1'b0}}}) |=>
      (out_word == {1'b1, EXP_W'(TOPX), {MAN_W{1'b0}}} && !underflow));

   // R7: flushed result is a signed zero, flagged only with a valid result
   p_uf_flush_r7: assert property (@(posedge clk) disable iff (rst)
      underflow |-> (out_valid && out_word[OW-2:0] == '0));

   // R8: one-cycle latency and idle behaviour
   p_lat_r8: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   p_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !underflow && $stable(out_word)));

endmodule

bind fxp2flt_conv fxp2flt_chk #(
   .IN_W(IN_W), .INT_W(INT_W), .EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_word  (out_word),
   .underflow (underflow)
);

// File: tb/sim_fxp2flt_conv.sv
module sim_fxp2flt_conv;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = 16'h0;
   logic        out_valid;
   logic [15:0] out_word;
   logic        underflow;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   fxp2flt_conv u0 (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_word  (out_word),
      .underflow (underflow)
   );

   // Reference: {underflow, word}, computed from the requirements
   function automatic logic [16:0] ref_conv(input logic [15:0] x);
      logic [16:0] m;
      logic [15:0] nrm;
      int          p;
      m = x[15] ? (17'h10000 - {1'b0, x}) : {1'b0, x};
      p = -1;
      for (int i = 0; i < 16; i++) if (m[i]) p = i;
      if (p < 0) return 17'h0;
      if (p < 3) return {1'b1, x[15], 15'h0};
      nrm = m[15:0] << (15 - p);
      return {1'b0, x[15], 4'(p - 3), nrm[14:4]};
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Strobe one word; check the result and the idle cycle after it
   task automatic convert(input logic [15:0] d, input string tag);
      logic [16:0] e;
      logic [15:0] held;
      e = ref_conv(d);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'($urandom);
      check(out_valid == 1'b1, {tag, " R8 valid"}, 32'(out_valid), 32'h1);
      check(out_word == e[15:0], tag, 32'(out_word), 32'(e[15:0]));
      check(underflow == e[16], {tag, " R7 flag"}, 32'(underflow), 32'(e[16]));
      held = out_word;
      @(negedge clk);
      check(!out_valid && !underflow && out_word == held, "R8 idle hold",
            {14'h0, out_valid, underflow, out_word}, {16'h0, held});
   endtask

   initial begin
      logic [16:0] e1;
      logic [16:0] e2;
      logic [16:0] ra;
      logic [16:0] rb;
      logic [15:0] a;
      logic [15:0] b;
      void'($urandom(32'h5EED_0C0F));

      // R9: reset dominates a strobe
      in_valid = 1'b1;
      in_data  = 16'h2080;
      repeat (3) @(negedge clk);
      check(!out_valid && !underflow && out_word == 16'h0, "R9 reset",
            {14'h0, out_valid, underflow, out_word}, 32'h0);
      rst = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      check(!out_valid, "R9 R8 no strobe after reset", 32'(out_valid), 32'h0);

      // Directed corners
      convert(16'h2080, "R4 R2 R3 8.125");
      check(ref_conv(16'h2080) == 17'h05020, "R4 model", 32'(ref_conv(16'h2080)), 32'h5020);
      convert(16'h0400, "R4 1.0");
      convert(16'h7FFF, "R2 truncation max");
      convert(16'h0000, "R5 zero");
      convert(16'h8000, "R6 most negative");
      convert(16'hFFFF, "R7 minus one");
      convert(16'h0007, "R7 seven");
      convert(16'h0008, "R7 R3 eight exp0");
      convert(16'hFFF8, "R1 R7 minus eight");
      convert(16'hDF80, "R1 -8.125");

      // R1: negation gives the same magnitude bits
      a = 16'h1234;
      b = 16'h0000 - a;
      ra = ref_conv(a);
      rb = ref_conv(b);
      convert(a, "R1 pos");
      convert(b, "R1 neg");
      check(ra[14:0] == rb[14:0] && rb[15], "R1 model symmetry",
            32'(rb[15:0]), 32'({1'b1, ra[14:0]}));

      // R8: back-to-back strobes
      e1 = ref_conv(16'h2080);
      e2 = ref_conv(16'h8000);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 16'h2080;
      @(negedge clk);
      in_data  = 16'h8000;
      check(out_valid && out_word == e1[15:0], "R8 b2b first",
            32'(out_word), 32'(e1[15:0]));
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid && out_word == e2[15:0], "R8 b2b second",
            32'(out_word), 32'(e2[15:0]));
      @(negedge clk);
      check(!out_valid, "R8 b2b end", 32'(out_valid), 32'h0);

      // Constrained random
      for (int n = 0; n < 300; n++) begin
         logic [15:0] d;
         case (n % 3)
            0: d = 16'($urandom);
            1: begin
               d = 16'($urandom_range(1, 9));
               if ($urandom_range(0, 1) == 1) d = 16'h0 - d;
            end
            default: begin
               d = 16'h1 << $urandom_range(0, 15);
               if ($urandom_range(0, 1) == 1) d = 16'h0 - d;
            end
         endcase
         convert(d, "R2 R3 R4 random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=0", 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule